// File: doc/BRIEF.md
# Two-Level Nested Interrupt Arbiter

This block gathers the interrupt requests of a small microcontroller core and decides which one the CPU should vector to next. Its sources are two external interrupt pins, three timers, an I2C unit and two serial ports. Each source has an enable bit and a priority bit held in four 8-bit registers. The CPU reads and writes these registers over a simple special-function-register bus with a combinational read path.

Every source is assigned to one of two levels, low or high. A high-level request wins over any low-level request. Within one level, a fixed ten-slot polling order picks the winner. Two of the ten slots are reserved and never win. The block keeps one in-service flag per level, so a high-level request can interrupt a low-level routine, while nothing can interrupt a high-level routine. The CPU pulses `irq_ack` when it enters the routine for the offered slot, and pulses `irq_ret` when a routine finishes.

Top module: `irq_nest_ctrl`

## Requirements
- R1: After reset, all four configuration registers read 0x00, `irq_valid` is low and both in-service levels are idle.
- R2: The registers are at these addresses: main enable 0xA8, secondary enable 0xA7, main priority 0xB8, secondary priority 0xB7. A write stores only the implemented bits. Those are 0xBF for main enable, 0x12 for secondary enable, 0x3F for main priority and 0x12 for secondary priority. All other bits, and reads from any other address, return 0.
- R3: When bit 7 of the main enable register (global enable) is 0, `irq_valid` stays low whatever the requests and the other enable bits are.
- R4: Each source is gated by its own enable bit:
  - main enable: ext0 bit 0, timer0 bit 1, ext1 bit 2, timer1 bit 3, serial 1 bit 4, timer2 bit 5;
  - secondary enable: I2C bit 1, serial 2 bit 4.
- R5: Among pending requests of the same level, the lowest slot wins. `irq_slot` carries that slot as a 4-bit code: ext0=0, serial 2=1, timer0=2, I2C=3, ext1=4, reserved=5, timer1=6, reserved=7, serial 1=8, timer2=9.
- R6: A pending high-level request always beats any low-level request. The level bits sit at the same positions as the enable bits, in the main priority register (ext0 0, timer0 1, ext1 2, timer1 3, serial 1 4, timer2 5) and in the secondary priority register (I2C 1, serial 2 4).
- R7: A serial port requests while its receive flag or its transmit flag is high. Timer 2 requests while its overflow flag or its external flag is high. The arbiter never clears these flags.
- R8: `irq_ack` while `irq_valid` is high marks the offered slot's level as in service. While low is in service, low-level requests are not offered, but high-level requests are.
- R9: While high is in service, `irq_valid` stays low.
- R10: `irq_ret` clears the high in-service flag if it is set, and otherwise clears the low flag.
- R11: When `irq_ack` and `irq_ret` arrive in the same cycle, the return clears a flag first, and then the acknowledge sets the level of the slot offered in that cycle.
- R12: Slots 5 and 7 are never offered.
- R13: `irq_ack` while `irq_valid` is low changes no in-service state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sfr_addr | input | 8 | Register address |
| sfr_we | input | 1 | Register write strobe |
| sfr_wdata | input | 8 | Register write data |
| sfr_rdata | output | 8 | Register read data (combinational) |
| ext0_req | input | 1 | External interrupt 0 request |
| ext1_req | input | 1 | External interrupt 1 request |
| tmr0_req | input | 1 | Timer 0 request |
| tmr1_req | input | 1 | Timer 1 request |
| tmr2_ovf | input | 1 | Timer 2 overflow flag |
| tmr2_ext | input | 1 | Timer 2 external flag |
| i2c_req | input | 1 | I2C request |
| ser1_rx | input | 1 | Serial port 1 receive flag |
| ser1_tx | input | 1 | Serial port 1 transmit flag |
| ser2_rx | input | 1 | Serial port 2 receive flag |
| ser2_tx | input | 1 | Serial port 2 transmit flag |
| irq_ack | input | 1 | CPU entered the routine for the offered slot |
| irq_ret | input | 1 | CPU returned from a routine |
| irq_valid | output | 1 | A request is offered |
| irq_slot | output | 4 | Offered slot code |

## Verification
An acknowledge and a return can land in the same clock edge. They then both update the in-service flags, and their order decides what state results. The bench provokes this case in two steps:
- it first puts the low level in service;
- it then offers a high-level slot and pulses `irq_ack` and `irq_ret` together.

It judges the result at the ports. `irq_valid` must stay low, which shows that high is now in service. After one further return, a low-level request must be offered again, which proves the low flag was the one cleared.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;
  localparam int NSLOT  = 10;
  localparam int SLOT_W = $clog2(NSLOT);
  localparam int DW     = 8;

  localparam int SL_EXT0 = 0;
  localparam int SL_SER2 = 1;
  localparam int SL_TMR0 = 2;
  localparam int SL_I2C  = 3;
  localparam int SL_EXT1 = 4;
  localparam int SL_RSV5 = 5;
  localparam int SL_TMR1 = 6;
  localparam int SL_RSV7 = 7;
  localparam int SL_SER1 = 8;
  localparam int SL_TMR2 = 9;

  // slots that can ever be granted (5 and 7 held at zero)
  localparam logic [NSLOT-1:0] SLOT_LIVE = 10'b11_0101_1111;

  localparam logic [DW-1:0] MAIN_EN_MASK  = 8'hBF;
  localparam logic [DW-1:0] AUX_EN_MASK   = 8'h12;
  localparam logic [DW-1:0] MAIN_LVL_MASK = 8'h3F;
  localparam logic [DW-1:0] AUX_LVL_MASK  = 8'h12;

  localparam int GLOBAL_EN_BIT = 7;

  typedef struct packed {
    logic [DW-1:0] main_en;
    logic [DW-1:0] aux_en;
    logic [DW-1:0] main_lvl;
    logic [DW-1:0] aux_lvl;
  } irq_cfg_t;
endpackage

// File: rtl/irq_sfr_regs.sv
module irq_sfr_regs
  import irq_nest_pkg::*;
#(
  parameter int               AW            = 8,
  parameter logic [AW-1:0]    ADDR_MAIN_EN  = 8'hA8,
  parameter logic [AW-1:0]    ADDR_AUX_EN   = 8'hA7,
  parameter logic [AW-1:0]    ADDR_MAIN_LVL = 8'hB8,
  parameter logic [AW-1:0]    ADDR_AUX_LVL  = 8'hB7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output irq_cfg_t      cfg
);
  irq_cfg_t cfg_q, cfg_d;
  logic     cfg_en;

  always_comb begin
    cfg_d  = cfg_q;
    cfg_en = 1'b0;
    if (we) begin
      unique case (addr)
        ADDR_MAIN_EN:  begin cfg_d.main_en  = wdata & MAIN_EN_MASK;  cfg_en = 1'b1; end
        ADDR_AUX_EN:   begin cfg_d.aux_en   = wdata & AUX_EN_MASK;   cfg_en = 1'b1; end
        ADDR_MAIN_LVL: begin cfg_d.main_lvl = wdata & MAIN_LVL_MASK; cfg_en = 1'b1; end
        ADDR_AUX_LVL:  begin cfg_d.aux_lvl  = wdata & AUX_LVL_MASK;  cfg_en = 1'b1; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_en) cfg_q <= cfg_d;
  end

  always_comb begin
    unique case (addr)
      ADDR_MAIN_EN:  rdata = cfg_q.main_en;
      ADDR_AUX_EN:   rdata = cfg_q.aux_en;
      ADDR_MAIN_LVL: rdata = cfg_q.main_lvl;
      ADDR_AUX_LVL:  rdata = cfg_q.aux_lvl;
      default:       rdata = '0;
    endcase
  end

  assign cfg = cfg_q;
endmodule

// File: rtl/irq_src_map.sv
module irq_src_map
  import irq_nest_pkg::*;
(
  input  irq_cfg_t          cfg,
  input  logic              ext0_req,
  input  logic              ext1_req,
  input  logic              tmr0_req,
  input  logic              tmr1_req,
  input  logic              tmr2_ovf,
  input  logic              tmr2_ext,
  input  logic              i2c_req,
  input  logic              ser1_rx,
  input  logic              ser1_tx,
  input  logic              ser2_rx,
  input  logic              ser2_tx,
  output logic [NSLOT-1:0]  pend,
  output logic [NSLOT-1:0]  lvl_hi
);
  logic [NSLOT-1:0] raw, en, lvl;
  logic             unused_cfg;

  always_comb begin
    raw = '0; en = '0; lvl = '0;
    raw[SL_EXT0] = ext0_req;            en[SL_EXT0] = cfg.main_en[0]; lvl[SL_EXT0] = cfg.main_lvl[0];
    raw[SL_SER2] = ser2_rx | ser2_tx;   en[SL_SER2] = cfg.aux_en[4];  lvl[SL_SER2] = cfg.aux_lvl[4];
    raw[SL_TMR0] = tmr0_req;            en[SL_TMR0] = cfg.main_en[1]; lvl[SL_TMR0] = cfg.main_lvl[1];
    raw[SL_I2C]  = i2c_req;             en[SL_I2C]  = cfg.aux_en[1];  lvl[SL_I2C]  = cfg.aux_lvl[1];
    raw[SL_EXT1] = ext1_req;            en[SL_EXT1] = cfg.main_en[2]; lvl[SL_EXT1] = cfg.main_lvl[2];
    raw[SL_TMR1] = tmr1_req;            en[SL_TMR1] = cfg.main_en[3]; lvl[SL_TMR1] = cfg.main_lvl[3];
    raw[SL_SER1] = ser1_rx | ser1_tx;   en[SL_SER1] = cfg.main_en[4]; lvl[SL_SER1] = cfg.main_lvl[4];
    raw[SL_TMR2] = tmr2_ovf | tmr2_ext; en[SL_TMR2] = cfg.main_en[5]; lvl[SL_TMR2] = cfg.main_lvl[5];
  end

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    if (SLOT_LIVE[s]) begin : g_live
      assign pend[s]   = raw[s] & en[s] & cfg.main_en[GLOBAL_EN_BIT];
      assign lvl_hi[s] = lvl[s];
    end else begin : g_rsv
      assign pend[s]   = 1'b0;
      assign lvl_hi[s] = 1'b0;
    end
  end

  assign unused_cfg = ^{cfg.main_en[6], cfg.aux_en[7:5], cfg.aux_en[3:2], cfg.aux_en[0],
                        cfg.main_lvl[7:6], cfg.aux_lvl[7:5], cfg.aux_lvl[3:2], cfg.aux_lvl[0],
                        raw[SL_RSV5], raw[SL_RSV7], en[SL_RSV5], en[SL_RSV7],
                        lvl[SL_RSV5], lvl[SL_RSV7]};
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int NSLOT  = 10,
  parameter int SLOT_W = $clog2(NSLOT)
) (
  input  logic [NSLOT-1:0]  pend,
  input  logic [NSLOT-1:0]  lvl_hi,
  input  logic              isr_hi,
  input  logic              isr_lo,
  output logic              valid,
  output logic              grant_hi,
  output logic [SLOT_W-1:0] slot
);
  logic [NSLOT-1:0]  hi_req, lo_req;
  logic [SLOT_W-1:0] hi_idx, lo_idx;
  logic              hi_ok, lo_ok;

  assign hi_req = pend & lvl_hi;
  assign lo_req = pend & ~lvl_hi;

  // scan from the bottom of the order up; the last hit is the winner
  always_comb begin
    hi_idx = '0;
    lo_idx = '0;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      if (hi_req[i]) hi_idx = SLOT_W'(i);
      if (lo_req[i]) lo_idx = SLOT_W'(i);
    end
  end

  assign hi_ok    = (|hi_req) & ~isr_hi;
  assign lo_ok    = (|lo_req) & ~isr_hi & ~isr_lo;
  assign valid    = hi_ok | lo_ok;
  assign grant_hi = hi_ok;
  assign slot     = hi_ok ? hi_idx : (lo_ok ? lo_idx : '0);
endmodule

// File: rtl/irq_isr_track.sv
module irq_isr_track (
  input  logic clk,
  input  logic rst_n,
  input  logic ack,
  input  logic ret,
  input  logic valid,
  input  logic grant_hi,
  output logic isr_hi,
  output logic isr_lo
);
  logic hi_q, lo_q, hi_d, lo_d, upd;

  always_comb begin
    hi_d = hi_q;
    lo_d = lo_q;
    if (ret) begin
      if (hi_q) hi_d = 1'b0;
      else      lo_d = 1'b0;
    end
    if (ack && valid) begin
      if (grant_hi) hi_d = 1'b1;
      else          lo_d = 1'b1;
    end
    upd = ret | (ack & valid);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= 1'b0;
      lo_q <= 1'b0;
    end else if (upd) begin
      hi_q <= hi_d;
      lo_q <= lo_d;
    end
  end

  assign isr_hi = hi_q;
  assign isr_lo = lo_q;
endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl
  import irq_nest_pkg::*;
#(
  parameter int            AW            = 8,
  parameter logic [AW-1:0] ADDR_MAIN_EN  = 8'hA8,
  parameter logic [AW-1:0] ADDR_AUX_EN   = 8'hA7,
  parameter logic [AW-1:0] ADDR_MAIN_LVL = 8'hB8,
  parameter logic [AW-1:0] ADDR_AUX_LVL  = 8'hB7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     sfr_addr,
  input  logic              sfr_we,
  input  logic [DW-1:0]     sfr_wdata,
  output logic [DW-1:0]     sfr_rdata,
  input  logic              ext0_req,
  input  logic              ext1_req,
  input  logic              tmr0_req,
  input  logic              tmr1_req,
  input  logic              tmr2_ovf,
  input  logic              tmr2_ext,
  input  logic              i2c_req,
  input  logic              ser1_rx,
  input  logic              ser1_tx,
  input  logic              ser2_rx,
  input  logic              ser2_tx,
  input  logic              irq_ack,
  input  logic              irq_ret,
  output logic              irq_valid,
  output logic [SLOT_W-1:0] irq_slot
);
  logic [1:0]       rst_sync;
  logic             rst_core_n;
  irq_cfg_t         cfg;
  logic [NSLOT-1:0] pend, lvl_hi;
  logic             isr_hi, isr_lo, grant_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_core_n = rst_sync[1];

  irq_sfr_regs #(
    .AW(AW), .ADDR_MAIN_EN(ADDR_MAIN_EN), .ADDR_AUX_EN(ADDR_AUX_EN),
    .ADDR_MAIN_LVL(ADDR_MAIN_LVL), .ADDR_AUX_LVL(ADDR_AUX_LVL)
  ) u_regs (
    .clk(clk), .rst_n(rst_core_n), .addr(sfr_addr), .we(sfr_we),
    .wdata(sfr_wdata), .rdata(sfr_rdata), .cfg(cfg)
  );

  irq_src_map u_map (
    .cfg(cfg), .ext0_req(ext0_req), .ext1_req(ext1_req),
    .tmr0_req(tmr0_req), .tmr1_req(tmr1_req), .tmr2_ovf(tmr2_ovf),
    .tmr2_ext(tmr2_ext), .i2c_req(i2c_req), .ser1_rx(ser1_rx),
    .ser1_tx(ser1_tx), .ser2_rx(ser2_rx), .ser2_tx(ser2_tx),
    .pend(pend), .lvl_hi(lvl_hi)
  );

  irq_pick #(.NSLOT(NSLOT), .SLOT_W(SLOT_W)) u_pick (
    .pend(pend), .lvl_hi(lvl_hi), .isr_hi(isr_hi), .isr_lo(isr_lo),
    .valid(irq_valid), .grant_hi(grant_hi), .slot(irq_slot)
  );

  irq_isr_track u_isr (
    .clk(clk), .rst_n(rst_core_n), .ack(irq_ack), .ret(irq_ret),
    .valid(irq_valid), .grant_hi(grant_hi), .isr_hi(isr_hi), .isr_lo(isr_lo)
  );
endmodule

// File: rtl/irq_nest_chk.sv
module irq_nest_chk
  import irq_nest_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              irq_ack,
  input logic              irq_ret,
  input logic              irq_valid,
  input logic [SLOT_W-1:0] irq_slot,
  input logic              isr_hi,
  input logic              isr_lo,
  input logic              grant_hi,
  input logic [DW-1:0]     main_en
);
  assert_global_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !main_en[GLOBAL_EN_BIT] |-> !irq_valid);

  assert_lo_masks_lo_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (isr_lo && irq_valid) |-> grant_hi);

  assert_ack_marks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && irq_valid && !irq_ret) |=> (isr_hi || isr_lo));

  assert_hi_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    isr_hi |-> !irq_valid);

  assert_ret_hi_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ret && !irq_ack && isr_hi) |=> (!isr_hi && isr_lo == $past(isr_lo)));

  assert_ret_then_lo_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ret && !irq_ack && !isr_hi) |=> (!isr_lo && !isr_hi));

  assert_both_edge_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ret && irq_ack && irq_valid && grant_hi && !isr_hi) |=> (isr_hi && !isr_lo));

  assert_no_rsvd_R12: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (irq_slot != SLOT_W'(SL_RSV5) && irq_slot != SLOT_W'(SL_RSV7)));

  assert_idle_ack_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !irq_valid && !irq_ret) |=> ($stable(isr_hi) && $stable(isr_lo)));
endmodule

bind irq_nest_ctrl irq_nest_chk u_chk (
  .clk(clk), .rst_n(rst_n), .irq_ack(irq_ack), .irq_ret(irq_ret),
  .irq_valid(irq_valid), .irq_slot(irq_slot), .isr_hi(isr_hi),
  .isr_lo(isr_lo), .grant_hi(grant_hi), .main_en(cfg.main_en)
);

// File: tb/tb_irq_nest_ctrl.sv
module tb_irq_nest_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  sfr_addr, sfr_wdata, sfr_rdata;
  logic        sfr_we, irq_ack, irq_ret, irq_valid;
  logic [3:0]  irq_slot;
  // req bits: 0 ext0, 1 ser2_rx, 2 ser2_tx, 3 tmr0, 4 i2c, 5 ext1,
  //           6 tmr1, 7 ser1_rx, 8 ser1_tx, 9 tmr2_ovf, 10 tmr2_ext
  logic [10:0] req;
  int          errors = 0, checks = 0;
  bit          done = 0;

  always #5 clk = ~clk;

  irq_nest_ctrl dut (
    .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_we(sfr_we),
    .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata),
    .ext0_req(req[0]), .ext1_req(req[5]), .tmr0_req(req[3]), .tmr1_req(req[6]),
    .tmr2_ovf(req[9]), .tmr2_ext(req[10]), .i2c_req(req[4]),
    .ser1_rx(req[7]), .ser1_tx(req[8]), .ser2_rx(req[1]), .ser2_tx(req[2]),
    .irq_ack(irq_ack), .irq_ret(irq_ret), .irq_valid(irq_valid), .irq_slot(irq_slot)
  );

  typedef struct packed {
    logic [7:0]  men, aen, mlv, alv;
    logic [10:0] rq;
    logic        v;
    logic [3:0]  sl;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VT [NV] = '{
    '{8'h3F, 8'h12, 8'h00, 8'h00, 11'h7FF, 1'b0, 4'd0}, // R3 global off
    '{8'hBF, 8'h12, 8'h00, 8'h00, 11'h7FF, 1'b1, 4'd0}, // R5 ext0 first
    '{8'hBF, 8'h12, 8'h00, 8'h00, 11'h7FE, 1'b1, 4'd1}, // R5 ser2
    '{8'hBF, 8'h12, 8'h00, 8'h00, 11'h204, 1'b1, 4'd1}, // R7 ser2 tx only
    '{8'hBF, 8'h12, 8'h00, 8'h00, 11'h7F8, 1'b1, 4'd2}, // R5 tmr0
    '{8'hBF, 8'h12, 8'h00, 8'h00, 11'h7F0, 1'b1, 4'd3}, // R5 i2c
    '{8'hBF, 8'h12, 8'h00, 8'h00, 11'h7E0, 1'b1, 4'd4}, // R5 ext1
    '{8'hBF, 8'h12, 8'h00, 8'h00, 11'h7C0, 1'b1, 4'd6}, // R5 R12 skip 5
    '{8'hBF, 8'h12, 8'h00, 8'h00, 11'h100, 1'b1, 4'd8}, // R7 ser1 tx
    '{8'hBF, 8'h12, 8'h00, 8'h00, 11'h400, 1'b1, 4'd9}, // R7 tmr2 ext
    '{8'hBF, 8'h12, 8'h20, 8'h00, 11'h7FF, 1'b1, 4'd9}, // R6 tmr2 high
    '{8'hBF, 8'h12, 8'h00, 8'h02, 11'h7FF, 1'b1, 4'd3}, // R6 i2c high
    '{8'h88, 8'h00, 8'h00, 8'h00, 11'h7FF, 1'b1, 4'd6}, // R4 only tmr1
    '{8'h80, 8'h10, 8'h00, 8'h00, 11'h7FF, 1'b1, 4'd1}, // R4 only ser2
    '{8'h80, 8'h00, 8'h00, 8'h00, 11'h7FF, 1'b0, 4'd0}, // R4 none enabled
    '{8'hBF, 8'h12, 8'h3F, 8'h12, 11'h7FF, 1'b1, 4'd0}  // R6 all high, order
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); sfr_addr = a; sfr_wdata = d; sfr_we = 1'b1;
    @(negedge clk); sfr_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); sfr_addr = a; #1 d = sfr_rdata;
  endtask

  task automatic pulse(input logic a, input logic r);
    @(negedge clk); irq_ack = a; irq_ret = r;
    @(negedge clk); irq_ack = 1'b0; irq_ret = 1'b0;
  endtask

  task automatic settle;
    @(negedge clk); #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    rst_n = 1'b0; sfr_addr = '0; sfr_wdata = '0; sfr_we = 1'b0;
    irq_ack = 1'b0; irq_ret = 1'b0; req = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk("R1 valid after reset", irq_valid, 0);
    rd(8'hA8, d); chk("R1 main_en reset", d, 8'h00);
    rd(8'hA7, d); chk("R1 aux_en reset", d, 8'h00);
    rd(8'hB8, d); chk("R1 main_lvl reset", d, 8'h00);
    rd(8'hB7, d); chk("R1 aux_lvl reset", d, 8'h00);
    // R2 implemented bits
    wr(8'hA8, 8'hFF); wr(8'hA7, 8'hFF); wr(8'hB8, 8'hFF); wr(8'hB7, 8'hFF);
    rd(8'hA8, d); chk("R2 main_en mask", d, 8'hBF);
    rd(8'hA7, d); chk("R2 aux_en mask", d, 8'h12);
    rd(8'hB8, d); chk("R2 main_lvl mask", d, 8'h3F);
    rd(8'hB7, d); chk("R2 aux_lvl mask", d, 8'h12);
    rd(8'h80, d); chk("R2 unmapped read", d, 8'h00);

    for (int i = 0; i < NV; i++) begin
      wr(8'hA8, VT[i].men); wr(8'hA7, VT[i].aen);
      wr(8'hB8, VT[i].mlv); wr(8'hB7, VT[i].alv);
      req = VT[i].rq;
      settle();
      chk($sformatf("R3-table row %0d valid", i), irq_valid, VT[i].v);
      if (VT[i].v) chk($sformatf("R5-table row %0d slot", i), irq_slot, VT[i].sl);
    end

    // nesting: ext1 low, tmr1 and ext0 high
    req = '0;
    wr(8'hA8, 8'hBF); wr(8'hA7, 8'h00); wr(8'hB8, 8'h00); wr(8'hB7, 8'h00);
    req[5] = 1'b1; settle();
    chk("R8 low offered", irq_slot, 4);
    pulse(1'b1, 1'b0); settle();
    chk("R8 low in service masks low", irq_valid, 0);
    wr(8'hB8, 8'h09); req[6] = 1'b1; settle();
    chk("R8 high preempts low", irq_slot, 6);
    chk("R8 high preempt valid", irq_valid, 1);
    pulse(1'b1, 1'b0); req[0] = 1'b1; settle();
    chk("R9 high in service blocks", irq_valid, 0);
    pulse(1'b0, 1'b1); settle();
    chk("R10 ret clears high first", irq_slot, 0);
    chk("R10 high cleared valid", irq_valid, 1);
    req[0] = 1'b0; req[6] = 1'b0; settle();
    chk("R10 low still in service", irq_valid, 0);
    pulse(1'b0, 1'b1); settle();
    chk("R10 second ret clears low", irq_slot, 4);
    chk("R10 low offered again", irq_valid, 1);

    // R13: idle ack
    req = '0; settle();
    chk("R13 idle", irq_valid, 0);
    pulse(1'b1, 1'b0);
    req[5] = 1'b1; settle();
    chk("R13 idle ack ignored", irq_valid, 1);

    // R11: ack and ret together
    pulse(1'b1, 1'b0); settle();
    chk("R11 low in service", irq_valid, 0);
    req[6] = 1'b1; settle();
    chk("R11 high offered", irq_slot, 6);
    pulse(1'b1, 1'b1); settle();
    chk("R11 high now in service", irq_valid, 0);
    req[6] = 1'b0;
    pulse(1'b0, 1'b1); settle();
    chk("R11 low was cleared", irq_valid, 1);
    chk("R11 low slot", irq_slot, 4);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule